// File: doc/BRIEF.md
# DRAM Subsystem Reset Release Sequencer

This block drives the four reset lines of a DRAM controller and its PHY: a controller reset, a PHY reset, and separate resets for the analog and digital halves of the PHY. A start pulse asserts all four. The block then releases them one by one in a fixed order and waits a programmed number of reference-clock cycles between steps. The PHY reset goes first. The controller reset follows after a long wait. The PHY analog reset follows after a short wait. The PHY digital reset goes last, after a second long wait.

The wait lengths are given in microseconds and converted to cycles from the reference clock frequency. The long wait is stretched, if needed, so that the analog-to-digital gap covers at least the required number of DRAM clock cycles at the slowest allowed DRAM clock. When the last reset is released, a done level rises and stays high until the next start. An abort input puts every reset back into the asserted state and holds the block idle until a new start arrives.

Top module: `dram_rst_sequencer`

## Requirements
- R1: While the asynchronous reset rst_n is low, and afterwards until the first start, all four reset outputs are 1 (1 means held in reset) and done_o is 0.
- R2: The cycle after start_i is sampled high, all four reset outputs are 1 and done_o is 0.
- R3: The PHY reset output goes to 0 exactly SHORT_CYC cycles after the start edge (200 with defaults: 1 us at 200 MHz), while the controller reset is still 1.
- R4: The controller reset goes to 0 exactly LONG_CYC cycles after the PHY reset release (1000 with defaults: 5 us). The controller reset is never 0 while the PHY reset is 1.
- R5: The PHY analog reset goes to 0 exactly SHORT_CYC cycles after the controller release, while the PHY digital reset is still 1.
- R6: The PHY digital reset goes to 0 exactly LONG_CYC cycles after the analog release. That gap is never shorter than ceil(DRAM_GAP_CYC*REF_CLK_MHZ/DRAM_MIN_MHZ) reference cycles.
- R7: done_o rises on the same edge as the digital release, only while all four resets are 0, and stays 1 until the next start or abort.
- R8: A start arriving mid-sequence or after done re-asserts all four resets and restarts the full timing from that start edge.
- R9: abort_i re-asserts all four resets and clears done_o on the next cycle, and the block then stays halted until a later start. When abort_i and start_i are high together, the abort wins.
- R10: Once a reset output has been released, it stays 0 until a start, an abort or rst_n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Single-cycle request to run the sequence |
| abort_i | input | 1 | Re-assert all resets and halt |
| ctrl_rst_o | output | 1 | Controller reset, 1 = asserted |
| phy_rst_o | output | 1 | PHY reset, 1 = asserted |
| phy_ana_rst_o | output | 1 | PHY analog reset, 1 = asserted |
| phy_dig_rst_o | output | 1 | PHY digital reset, 1 = asserted |
| done_o | output | 1 | All resets released; held until the next start or abort |

## Verification
The assertions assume that start_i and abort_i are synchronous to clk. They also assume that rst_n is removed away from a clock edge, so the first sampled edge sees settled outputs. The stimulus drives every input on the falling edge and holds each pulse for exactly one rising edge, including the case where start and abort coincide. The ordering and gap checks assume the default timing parameters, and every step of the bench samples at the exact cycles implied by those parameters.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ALL_ON  = 3'd1,
    ST_PHY_OFF = 3'd2,
    ST_CTL_OFF = 3'd3,
    ST_ANA_OFF = 3'd4,
    ST_DONE    = 3'd5
  } rsq_state_e;

  typedef struct packed {
    logic ctl;
    logic phy;
    logic ana;
    logic dig;
    logic done;
  } rsq_out_t;

  localparam rsq_out_t RSQ_OUT_HELD = '{ctl: 1'b1, phy: 1'b1, ana: 1'b1, dig: 1'b1, done: 1'b0};

  function automatic rsq_out_t rsq_decode(rsq_state_e st);
    rsq_out_t o;
    o = RSQ_OUT_HELD;
    case (st)
      ST_PHY_OFF: o.phy = 1'b0;
      ST_CTL_OFF: begin o.phy = 1'b0; o.ctl = 1'b0; end
      ST_ANA_OFF: begin o.phy = 1'b0; o.ctl = 1'b0; o.ana = 1'b0; end
      ST_DONE:    o = '{ctl: 1'b0, phy: 1'b0, ana: 1'b0, dig: 1'b0, done: 1'b1};
      default:    o = RSQ_OUT_HELD;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/rsq_interval_cnt.sv
module rsq_interval_cnt #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load_i) begin
      cnt_en = 1'b1;
      cnt_d  = load_val_i;
    end else if (run_i && (cnt_q != '0)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_q == '0) |=> (cnt_q == '0)); // R10

endmodule

// File: rtl/rsq_step_fsm.sv
module rsq_step_fsm
  import rsq_pkg::*;
#(
  parameter int unsigned CNT_W     = 10,
  parameter int unsigned SHORT_CYC = 200,
  parameter int unsigned LONG_CYC  = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic             wait_done_i,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             run_o,
  output rsq_state_e       state_o,
  output rsq_state_e       state_nxt_o
);

  localparam logic [CNT_W-1:0] SHORT_LD = CNT_W'(SHORT_CYC - 1);
  localparam logic [CNT_W-1:0] LONG_LD  = CNT_W'(LONG_CYC - 1);

  rsq_state_e st_q, st_d;
  logic       st_en;

  always_comb begin
    st_d       = st_q;
    load_o     = 1'b0;
    load_val_o = SHORT_LD;
    if (abort_i) begin
      st_d = ST_IDLE;
    end else if (start_i) begin
      st_d       = ST_ALL_ON;
      load_o     = 1'b1;
      load_val_o = SHORT_LD;
    end else begin
      case (st_q)
        ST_ALL_ON: if (wait_done_i) begin
          st_d = ST_PHY_OFF; load_o = 1'b1; load_val_o = LONG_LD;
        end
        ST_PHY_OFF: if (wait_done_i) begin
          st_d = ST_CTL_OFF; load_o = 1'b1; load_val_o = SHORT_LD;
        end
        ST_CTL_OFF: if (wait_done_i) begin
          st_d = ST_ANA_OFF; load_o = 1'b1; load_val_o = LONG_LD;
        end
        ST_ANA_OFF: if (wait_done_i) st_d = ST_DONE;
        default: st_d = st_q;
      endcase
    end
  end

  assign st_en = (st_d != st_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     st_q <= ST_IDLE;
    else if (st_en) st_q <= st_d;
  end

  assign run_o       = (st_q == ST_ALL_ON) || (st_q == ST_PHY_OFF) ||
                       (st_q == ST_CTL_OFF) || (st_q == ST_ANA_OFF);
  assign state_o     = st_q;
  assign state_nxt_o = st_d;

  AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (st_q == ST_IDLE)); // R9
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !start_i) |=> (st_q == ST_IDLE)); // R9

endmodule

// File: rtl/rsq_out_regs.sv
module rsq_out_regs
  import rsq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       upd_i,
  input  rsq_state_e state_nxt_i,
  output rsq_out_t   out_o
);

  rsq_out_t out_q, out_d;

  always_comb out_d = rsq_decode(state_nxt_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     out_q <= RSQ_OUT_HELD;
    else if (upd_i) out_q <= out_d;
  end

  assign out_o = out_q;

  AST_PHY_BEFORE_CTL: assert property (@(posedge clk) disable iff (!rst_n)
    !out_q.ctl |-> !out_q.phy); // R4
  AST_ANA_BEFORE_DIG: assert property (@(posedge clk) disable iff (!rst_n)
    !out_q.dig |-> !out_q.ana); // R5
  AST_DONE_ALL_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    out_q.done |-> (!out_q.ctl && !out_q.phy && !out_q.ana && !out_q.dig)); // R7

endmodule

// File: rtl/dram_rst_sequencer.sv
module dram_rst_sequencer
  import rsq_pkg::*;
#(
  parameter int unsigned REF_CLK_MHZ  = 200,
  parameter int unsigned SHORT_US     = 1,
  parameter int unsigned LONG_US      = 5,
  parameter int unsigned DRAM_MIN_MHZ = 200,
  parameter int unsigned DRAM_GAP_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic abort_i,
  output logic ctrl_rst_o,
  output logic phy_rst_o,
  output logic phy_ana_rst_o,
  output logic phy_dig_rst_o,
  output logic done_o
);

  localparam int unsigned SHORT_CYC   = (SHORT_US * REF_CLK_MHZ < 1) ? 1 : SHORT_US * REF_CLK_MHZ;
  localparam int unsigned MIN_GAP_REF = (DRAM_GAP_CYC * REF_CLK_MHZ + DRAM_MIN_MHZ - 1) / DRAM_MIN_MHZ;
  localparam int unsigned LONG_RAW    = LONG_US * REF_CLK_MHZ;
  localparam int unsigned LONG_CYC    = (LONG_RAW < MIN_GAP_REF) ? MIN_GAP_REF :
                                        ((LONG_RAW < 1) ? 1 : LONG_RAW);
  localparam int unsigned MAX_CYC     = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int unsigned CNT_W       = $clog2(MAX_CYC + 1);
  localparam int unsigned GAP_W       = CNT_W + 1;

  logic             cnt_load, cnt_run, cnt_zero;
  logic [CNT_W-1:0] cnt_ld_val;
  rsq_state_e       st, st_nxt;
  rsq_out_t         outs;

  rsq_step_fsm #(
    .CNT_W     (CNT_W),
    .SHORT_CYC (SHORT_CYC),
    .LONG_CYC  (LONG_CYC)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .abort_i     (abort_i),
    .wait_done_i (cnt_zero),
    .load_o      (cnt_load),
    .load_val_o  (cnt_ld_val),
    .run_o       (cnt_run),
    .state_o     (st),
    .state_nxt_o (st_nxt)
  );

  rsq_interval_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (cnt_load),
    .load_val_i (cnt_ld_val),
    .run_i      (cnt_run),
    .zero_o     (cnt_zero)
  );

  rsq_out_regs u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .upd_i       (st_nxt != st),
    .state_nxt_i (st_nxt),
    .out_o       (outs)
  );

  assign ctrl_rst_o    = outs.ctl;
  assign phy_rst_o     = outs.phy;
  assign phy_ana_rst_o = outs.ana;
  assign phy_dig_rst_o = outs.dig;
  assign done_o        = outs.done;

  // Gap monitor: cycles since the analog reset was released, saturating.
  logic [GAP_W-1:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  gap_q <= '0;
    else if (phy_ana_rst_o)      gap_q <= '0;
    else if (gap_q != '1)        gap_q <= gap_q + 1'b1;
  end

  AST_DIG_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phy_dig_rst_o) |-> (gap_q >= GAP_W'(MIN_GAP_REF))); // R6
  AST_START_HOLDS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (ctrl_rst_o && phy_rst_o && phy_ana_rst_o && phy_dig_rst_o && !done_o)); // R2
  AST_ABORT_HOLDS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (ctrl_rst_o && phy_rst_o && phy_ana_rst_o && phy_dig_rst_o && !done_o)); // R9
  AST_PHY_STAYS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (!phy_rst_o && !start_i && !abort_i) |=> !phy_rst_o); // R10
  AST_CTL_STAYS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_rst_o && !start_i && !abort_i) |=> !ctrl_rst_o); // R10
  AST_DONE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i && !abort_i) |=> done_o); // R7

endmodule

// File: tb/dram_rst_sequencer_tb_top.sv
module dram_rst_sequencer_tb_top;

  localparam int S = 200;   // 1 us at 200 MHz
  localparam int L = 1000;  // 5 us at 200 MHz, equals 1000 DRAM cycles at 200 MHz

  logic clk = 1'b0;
  logic rst_n, start, abort;
  logic ctl, phy, ana, dig, done;
  int   n_cmp = 0;
  int   n_err = 0;

  always #2.5 clk = ~clk;

  dram_rst_sequencer dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start),
    .abort_i       (abort),
    .ctrl_rst_o    (ctl),
    .phy_rst_o     (phy),
    .phy_ana_rst_o (ana),
    .phy_dig_rst_o (dig),
    .done_o        (done)
  );

  // vector order {ctl, phy, ana, dig, done}
  localparam logic [4:0] V_HELD = 5'b11110;
  localparam logic [4:0] V_PHY  = 5'b10110;
  localparam logic [4:0] V_CTL  = 5'b00110;
  localparam logic [4:0] V_ANA  = 5'b00010;
  localparam logic [4:0] V_DONE = 5'b00001;

  task automatic check(input string req, input logic [4:0] exp);
    logic [4:0] act;
    act = {ctl, phy, ana, dig, done};
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%b exp=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic adv(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  // Called half a cycle after the start edge.
  task automatic check_seq(input string tag);
    check({"R2 ", tag}, V_HELD);
    adv(S - 1); check({"R3 before ", tag}, V_HELD);
    adv(1);     check({"R3 ", tag}, V_PHY);
    adv(L - 1); check({"R4 before ", tag}, V_PHY);
    adv(1);     check({"R4 ", tag}, V_CTL);
    adv(S - 1); check({"R5 before ", tag}, V_CTL);
    adv(1);     check({"R5 ", tag}, V_ANA);
    adv(L - 1); check({"R6 before ", tag}, V_ANA);
    adv(1);     check({"R6 R7 ", tag}, V_DONE);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; abort = 1'b0;
    adv(3);
    check("R1 in reset", V_HELD);
    rst_n = 1'b1;
    adv(20);
    check("R1 idle after reset", V_HELD);
  endtask

  task automatic t_full();
    pulse_start();
    check_seq("first run");
  endtask

  task automatic t_done_hold();
    adv(600);
    check("R7 done held", V_DONE);
  endtask

  task automatic t_restart_mid();
    pulse_start();
    adv(S + 10);
    check("R8 mid state", V_PHY);
    pulse_start();
    check_seq("R8 restart");
  endtask

  task automatic t_restart_from_done();
    pulse_start();
    check_seq("R8 from done");
  endtask

  task automatic t_abort();
    pulse_start();
    adv(S + L + 5);
    check("R9 pre-abort", V_CTL);
    @(negedge clk) abort = 1'b1;
    @(negedge clk) abort = 1'b0;
    check("R9 abort", V_HELD);
    adv(3000);
    check("R9 halted", V_HELD);
  endtask

  task automatic t_abort_wins();
    pulse_start();
    check_seq("before tie");
    @(negedge clk) begin abort = 1'b1; start = 1'b1; end
    @(negedge clk) begin abort = 1'b0; start = 1'b0; end
    check("R9 tie", V_HELD);
    adv(S + 5);
    check("R9 tie no run", V_HELD);
  endtask

  initial begin
    t_reset();
    t_full();
    t_done_hold();
    t_restart_mid();
    t_restart_from_done();
    t_abort();
    t_abort_wins();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_err++;
    $display("FAIL watchdog act=running exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end

endmodule